// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block gathers interrupt requests from peripherals into a byte-wide pending register and drives a single level-sensitive interrupt line toward the host. Software programs a primary mask through a small register bus. A cleared mask bit lets the matching pending bit reach the output, and a set mask bit blocks it. Internally the mask is kept inverted, as an enable set, and it is complemented again on read-back. Software retires a pending source by writing its 4-bit index to the acknowledge register. Hardware sources set or clear pending bits through two request vectors that act for one cycle.

A secondary mask register exists so that software can store and read back a value. It has no effect on the interrupt line, and its status register always reads zero. Reads are combinational on the register bus. A read is either a byte read or a 64-bit wide read. Only the primary status supports the wide form; a wide read of any other register returns zero. Writes and request pulses are committed at a clock edge, and `irq_out` is registered so that it changes at that same edge. Register map (`bus_addr`): 0 primary mask, 1 primary status (read) and acknowledge (write), 2 secondary mask, 3 secondary status.

Top module: `intr_pend_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0, the primary mask reads 0xFF, and the primary status, secondary mask and secondary status all read 0x00.
- R2: A write to address 0 stores the complement of the byte as the enable set. A later read of address 0 returns the byte that was written.
- R3: After each clock edge, `irq_out` is 1 exactly when some pending bit has its enable bit set, and 0 otherwise.
- R4: A write to address 1 clears the pending bit indexed by `bus_wdata[3:0]`, and bits [7:4] are ignored. An index of 8 to 15 leaves the pending register unchanged.
- R5: A mask write alters `irq_out` at the edge that commits it. The line rises if unmasked pending bits now exist, and falls if none remain.
- R6: A byte read of address 1 returns the pending register. A wide read (`bus_rd_wide`=1) of address 1 returns the pending value zero-extended to 64 bits, and a wide read of any other address returns 0.
- R7: A write to address 2 stores the byte uninverted and reads back unchanged. This value never influences `irq_out`, and address 3 always reads 0x00.
- R8: Each bit of `req_set` ORs its pending bit to 1, and each bit of `req_clr` clears its pending bit. Both take effect at the next clock edge, and `irq_out` follows at that edge.
- R9: If a bit is set through `req_set` and also cleared through `req_clr` or an acknowledge in the same cycle, that pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rd_wide | input | 1 | Selects a 64-bit read instead of a byte read |
| bus_rdata | output | 64 | Combinational read data |
| req_set | input | 8 | Per-source pending set pulses |
| req_clr | input | 8 | Per-source pending clear pulses |
| irq_out | output | 1 | Level interrupt toward the host |

## Verification
A hardware set pulse can land in the same cycle as a software acknowledge or a hardware clear aimed at the same bit. The bench provokes both cases: in one cycle it drives `req_set` together with an acknowledge write, and in another cycle together with `req_clr`. It then reads the status register and requires the bit to be set, with `irq_out` high while the bit is enabled. A mask write can also coincide with a change in pending state. The bench judges that case from `irq_out` and the status read taken right after the edge.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    REG_PRI_MASK = 2'd0,
    REG_PRI_STAT = 2'd1,
    REG_SEC_MASK = 2'd2,
    REG_SEC_STAT = 2'd3
  } reg_sel_e;

  localparam int unsigned ACK_CODE_W = 4;
endpackage

// File: rtl/ipc_pending.sv
module ipc_pending
  import ipc_pkg::*;
#(
  parameter int unsigned SRC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SRC_W-1:0]      set_i,
  input  logic [SRC_W-1:0]      clr_i,
  input  logic                  ack_v_i,
  input  logic [ACK_CODE_W-1:0] ack_code_i,
  output logic [SRC_W-1:0]      pend_d_o,
  output logic [SRC_W-1:0]      pend_q_o
);
  logic [SRC_W-1:0] ack_vec;

  // one-hot decode of the acknowledge index; codes past SRC_W hit nothing
  for (genvar i = 0; i < SRC_W; i++) begin : g_ack_dec
    assign ack_vec[i] = ack_v_i && (ack_code_i == ACK_CODE_W'(i));
  end

  // set is applied last so it overrides any clear of the same bit
  always_comb begin
    pend_d_o = (pend_q_o & ~(clr_i | ack_vec)) | set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q_o <= '0;
    else        pend_q_o <= pend_d_o;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q_o & $past(set_i)) == $past(set_i)));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((clr_i | ack_vec) & ~set_i) != '0) |=>
      ((pend_q_o & $past((clr_i | ack_vec) & ~set_i)) == '0));
endmodule

// File: rtl/ipc_enable.sv
module ipc_enable #(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pri_i,
  input  logic             wr_sec_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] en_d_o,
  output logic [SRC_W-1:0] en_q_o,
  output logic [SRC_W-1:0] sec_q_o
);
  always_comb begin
    en_d_o = wr_pri_i ? ~wdata_i : en_q_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q_o  <= '0;
      sec_q_o <= '0;
    end else begin
      en_q_o <= en_d_o;
      if (wr_sec_i) sec_q_o <= wdata_i;
    end
  end

  // R2
  enable_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pri_i |=> (en_q_o == ~$past(wdata_i)));

  // R7
  sec_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec_i |=> (sec_q_o == $past(wdata_i)));
endmodule

// File: rtl/intr_pend_ctrl.sv
module intr_pend_ctrl
  import ipc_pkg::*;
#(
  parameter int unsigned SRC_W = 8,
  parameter int unsigned RD_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic [1:0]       bus_addr,
  input  logic [SRC_W-1:0] bus_wdata,
  input  logic             bus_rd_wide,
  output logic [RD_W-1:0]  bus_rdata,
  input  logic [SRC_W-1:0] req_set,
  input  logic [SRC_W-1:0] req_clr,
  output logic             irq_out
);
  reg_sel_e         sel;
  logic             wr_pri, wr_ack, wr_sec;
  logic [SRC_W-1:0] pend_d, pend_q, en_d, en_q, sec_q;
  logic [SRC_W-1:0] byte_rd;
  logic             irq_q;

  assign sel    = reg_sel_e'(bus_addr);
  assign wr_pri = bus_wr_en && (sel == REG_PRI_MASK);
  assign wr_ack = bus_wr_en && (sel == REG_PRI_STAT);
  assign wr_sec = bus_wr_en && (sel == REG_SEC_MASK);

  ipc_pending #(.SRC_W(SRC_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (req_set),
    .clr_i      (req_clr),
    .ack_v_i    (wr_ack),
    .ack_code_i (bus_wdata[ACK_CODE_W-1:0]),
    .pend_d_o   (pend_d),
    .pend_q_o   (pend_q)
  );

  ipc_enable #(.SRC_W(SRC_W)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_pri_i (wr_pri),
    .wr_sec_i (wr_sec),
    .wdata_i  (bus_wdata),
    .en_d_o   (en_d),
    .en_q_o   (en_q),
    .sec_q_o  (sec_q)
  );

  // the flag looks at next-state values so it moves on the committing edge
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_d & en_d);
  end
  assign irq_out = irq_q;

  always_comb begin
    unique case (sel)
      REG_PRI_MASK: byte_rd = ~en_q;
      REG_PRI_STAT: byte_rd = pend_q;
      REG_SEC_MASK: byte_rd = sec_q;
      default:      byte_rd = '0;
    endcase
    if (bus_rd_wide) bus_rdata = (sel == REG_PRI_STAT) ? RD_W'(pend_q) : '0;
    else             bus_rdata = RD_W'(byte_rd);
  end

  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == |(pend_q & en_q)));
endmodule

// File: tb/intr_pend_ctrl_tb_top.sv
module intr_pend_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rd_wide;
  logic [63:0] bus_rdata;
  logic [7:0]  req_set, req_clr;
  logic        irq_out;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_pend_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_wide(bus_rd_wide), .bus_rdata(bus_rdata),
    .req_set(req_set), .req_clr(req_clr), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one committed cycle: drive after a falling edge, release after the next one
  task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] d,
                     input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    bus_wr_en = wr; bus_addr = a; bus_wdata = d; req_set = s; req_clr = c;
    @(negedge clk);
    bus_wr_en = 1'b0; req_set = '0; req_clr = '0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, input logic w, output logic [63:0] v);
    bus_addr = a; bus_rd_wide = w;
    #1;
    v = bus_rdata;
    bus_rd_wide = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk("R1 irq", 64'(irq_out), 64'h0);
    rd(2'd0, 1'b0, v); chk("R1 pri mask", v, 64'hFF);
    rd(2'd1, 1'b0, v); chk("R1 pri stat", v, 64'h0);
    rd(2'd2, 1'b0, v); chk("R1 sec mask", v, 64'h0);
    rd(2'd3, 1'b0, v); chk("R1 sec stat", v, 64'h0);
  endtask

  task automatic t_mask_rw();
    logic [63:0] v;
    cyc(1'b1, 2'd0, 8'h5A, 8'h00, 8'h00);
    rd(2'd0, 1'b0, v); chk("R2 mask readback", v, 64'h5A);
  endtask

  task automatic t_pending_irq();
    logic [63:0] v;
    cyc(1'b1, 2'd0, 8'hFF, 8'h00, 8'h00);
    cyc(1'b0, 2'd0, 8'h00, 8'h81, 8'h00);
    rd(2'd1, 1'b0, v); chk("R8 set pending", v, 64'h81);
    chk("R3 masked irq low", 64'(irq_out), 64'h0);
    cyc(1'b1, 2'd0, 8'h7F, 8'h00, 8'h00);
    chk("R5 unmask raises", 64'(irq_out), 64'h1);
    cyc(1'b1, 2'd0, 8'hFF, 8'h00, 8'h00);
    chk("R5 mask lowers", 64'(irq_out), 64'h0);
    cyc(1'b1, 2'd0, 8'hFE, 8'h00, 8'h00);
    chk("R3 bit0 enabled", 64'(irq_out), 64'h1);
    cyc(1'b0, 2'd0, 8'h00, 8'h00, 8'h01);
    rd(2'd1, 1'b0, v); chk("R8 clr pending", v, 64'h80);
    chk("R3 irq after clr", 64'(irq_out), 64'h0);
  endtask

  task automatic t_ack();
    logic [63:0] v;
    cyc(1'b1, 2'd0, 8'h00, 8'h00, 8'h00);
    chk("R3 all enabled", 64'(irq_out), 64'h1);
    cyc(1'b1, 2'd1, 8'hF7, 8'h00, 8'h00);
    rd(2'd1, 1'b0, v); chk("R4 ack bit7 upper ignored", v, 64'h0);
    chk("R4 irq after ack", 64'(irq_out), 64'h0);
    cyc(1'b0, 2'd0, 8'h00, 8'h04, 8'h00);
    cyc(1'b1, 2'd1, 8'h0A, 8'h00, 8'h00);
    rd(2'd1, 1'b0, v); chk("R4 code 10 no effect", v, 64'h04);
    chk("R3 irq held", 64'(irq_out), 64'h1);
    cyc(1'b1, 2'd1, 8'h02, 8'h00, 8'h00);
    rd(2'd1, 1'b0, v); chk("R4 ack bit2", v, 64'h0);
  endtask

  task automatic t_set_wins();
    logic [63:0] v;
    cyc(1'b1, 2'd1, 8'h03, 8'h08, 8'h00);
    rd(2'd1, 1'b0, v); chk("R9 set beats ack", v, 64'h08);
    cyc(1'b0, 2'd0, 8'h00, 8'h10, 8'h10);
    rd(2'd1, 1'b0, v); chk("R9 set beats clr", v, 64'h18);
    chk("R9 irq high", 64'(irq_out), 64'h1);
    cyc(1'b0, 2'd0, 8'h00, 8'h00, 8'h18);
    rd(2'd1, 1'b0, v); chk("R8 clr two bits", v, 64'h0);
  endtask

  task automatic t_secondary();
    logic [63:0] v;
    cyc(1'b1, 2'd0, 8'hFF, 8'h00, 8'h00);
    cyc(1'b1, 2'd2, 8'h3C, 8'h00, 8'h00);
    rd(2'd2, 1'b0, v); chk("R7 sec readback", v, 64'h3C);
    cyc(1'b1, 2'd2, 8'h00, 8'h00, 8'h00);
    cyc(1'b0, 2'd0, 8'h00, 8'hA5, 8'h00);
    chk("R7 sec mask no irq", 64'(irq_out), 64'h0);
    rd(2'd3, 1'b0, v); chk("R7 sec stat zero", v, 64'h0);
  endtask

  task automatic t_wide();
    logic [63:0] v;
    rd(2'd1, 1'b1, v); chk("R6 wide stat", v, 64'hA5);
    rd(2'd0, 1'b1, v); chk("R6 wide other zero", v, 64'h0);
    rd(2'd1, 1'b0, v); chk("R6 byte stat", v, 64'hA5);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_rd_wide = 1'b0; req_set = '0; req_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_mask_rw();
    t_pending_irq();
    t_ack();
    t_set_wins();
    t_secondary();
    t_wide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule